// File: doc/BRIEF.md
# PRBS Pattern Checker with Self-Synchronization

This block checks a serial receive bitstream against one of four pseudo-random patterns. While out of lock it loads every received bit into a local shift register and predicts the next bit from two taps. It declares lock once a run of correct predictions as long as the chosen register has been seen. In lock the register runs on its own predictions, and each received bit that disagrees is reported as a bit error.

Errors are counted in back-to-back, non-overlapping 48-bit windows. Eleven or more errors in one window drop the lock, and the checker then starts acquiring again from the received bits. Two sticky flags record bit errors and lock changes. Each flag is cleared by a one-cycle clear pulse and has its own interrupt enable. A receive-invert control flips the incoming bits before they are checked. A rising edge on the test enable restarts acquisition from an empty register.

Top module: `prbs_det`

## Requirements
- R1: After reset, sync_o, bit_err_o, err_flag_o, sync_flag_o and irq_o are all 0.
- R2: pat_sel_i selects the pattern: 00 = x^15+x^14+1, 01 = x^20+x^17+1, 10 = x^11+x^9+1, 11 = x^7+x^6+1. With the register of length L (bit 0 newest), the predicted bit is reg[L-1] xor reg[tap-1]. While out of sync, sync_o rises on the clock edge that accepts the L-th consecutive correctly predicted bit.
- R3: A prediction made while the L-bit register holds all zeros does not count toward sync, so an all-zero stream never gives sync.
- R4: When rx_inv_i is 1, each received bit is inverted before it is checked. An inverted pattern syncs with rx_inv_i=1 and never syncs with rx_inv_i=0.
- R5: While in sync, every accepted bit that differs from the prediction pulses bit_err_o high for one cycle, on the edge that accepts the bit. Out of sync, bit_err_o stays 0.
- R6: Within one 48-bit window, the 11th error drops sync_o on the edge that accepts that bit. Exactly 10 errors in a window keep sync.
- R7: The first window starts with the first bit after sync is declared. Windows follow back to back, and the error count restarts at each boundary, so errors spread over two windows with at most 10 in each keep sync.
- R8: When test_en_i is 0, bits are ignored and sync_o is 0 after the next edge. On the cycle where test_en_i rises, the register and the counters are cleared and that cycle's bit is dropped.
- R9: err_flag_o is set by each bit-error event and cleared by err_clr_i. An event in the same cycle as the clear leaves the flag set.
- R10: sync_flag_o is set by any change of sync_o, rising or falling, and cleared by sync_clr_i. An event in the same cycle as the clear leaves the flag set.
- R11: irq_o = (err_flag_o and err_ie_i) or (sync_flag_o and sync_ie_i).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| test_en_i | input | 1 | Checker enable; a rising edge restarts acquisition |
| pat_sel_i | input | 2 | Pattern select |
| rx_inv_i | input | 1 | Invert received bits |
| bit_valid_i | input | 1 | Strobe: bit_i holds a received bit this cycle |
| bit_i | input | 1 | Received data bit |
| err_clr_i | input | 1 | Clear pulse for the bit-error flag |
| sync_clr_i | input | 1 | Clear pulse for the sync-change flag |
| err_ie_i | input | 1 | Interrupt enable for the bit-error flag |
| sync_ie_i | input | 1 | Interrupt enable for the sync-change flag |
| sync_o | output | 1 | In sync |
| bit_err_o | output | 1 | One-cycle pulse per bit error while in sync |
| err_flag_o | output | 1 | Sticky bit-error flag |
| sync_flag_o | output | 1 | Sticky sync-change flag |
| irq_o | output | 1 | Interrupt request |

## Verification
Clean streams of all four patterns show that each select code maps to the right polynomial and that lock comes after exactly L good bits. An all-zero stream and an inverted stream without inversion enabled show that the checker rejects false lock. Placing errors directly tells exactly ten errors apart from eleven in one window. Placing them across a window boundary shows that the windows are fixed and that the count restarts at each boundary. Random runs with gaps in the valid strobe, sparse errors, enable drops and clear pulses that collide with events are compared bit by bit against a reference model.

// File: rtl/prbs_det_pkg.sv
package prbs_det_pkg;
  localparam int unsigned MAX_LEN = 20;
  localparam int unsigned LEN_W   = $clog2(MAX_LEN + 1);

  function automatic logic [LEN_W-1:0] pat_len(input logic [1:0] sel);
    case (sel)
      2'b00:   return LEN_W'(15);
      2'b01:   return LEN_W'(20);
      2'b10:   return LEN_W'(11);
      default: return LEN_W'(7);
    endcase
  endfunction

  function automatic logic [MAX_LEN-1:0] pat_mask(input logic [1:0] sel);
    return {MAX_LEN{1'b1}} >> (LEN_W'(MAX_LEN) - pat_len(sel));
  endfunction
endpackage

// File: rtl/prbs_det_lfsr.sv
module prbs_det_lfsr
  import prbs_det_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       clr_i,
  input  logic       shift_i,
  input  logic       load_i,
  input  logic       bit_i,
  input  logic [1:0] sel_i,
  output logic       pred_o,
  output logic       zero_o
);
  logic [MAX_LEN-1:0] st_q, mask;
  logic               nxt;

  assign mask = pat_mask(sel_i);

  always_comb begin
    case (sel_i)
      2'b00:   pred_o = st_q[14] ^ st_q[13];
      2'b01:   pred_o = st_q[19] ^ st_q[16];
      2'b10:   pred_o = st_q[10] ^ st_q[8];
      default: pred_o = st_q[6]  ^ st_q[5];
    endcase
  end

  assign zero_o = ~|(st_q & mask);
  assign nxt    = load_i ? bit_i : pred_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      st_q <= '0;
    else if (clr_i)   st_q <= '0;
    else if (shift_i) st_q <= {st_q[MAX_LEN-2:0], nxt} & mask;
  end

  p_clr_empty_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> zero_o);
endmodule

// File: rtl/prbs_det_win.sv
module prbs_det_win #(
  parameter int unsigned WIN_LEN = 48,
  parameter int unsigned ERR_LIM = 10
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic step_i,
  input  logic err_i,
  output logic lose_o
);
  localparam int unsigned WW = $clog2(WIN_LEN);
  localparam int unsigned EW = $clog2(ERR_LIM + 2);

  logic [WW-1:0] wcnt_q;
  logic [EW-1:0] ecnt_q, e_sum;

  assign e_sum  = ecnt_q + EW'(err_i);
  assign lose_o = step_i && (e_sum > EW'(ERR_LIM));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wcnt_q <= '0;
      ecnt_q <= '0;
    end else if (clr_i || lose_o) begin
      wcnt_q <= '0;
      ecnt_q <= '0;
    end else if (step_i) begin
      if (wcnt_q == WW'(WIN_LEN - 1)) begin
        wcnt_q <= '0;
        ecnt_q <= '0;
      end else begin
        wcnt_q <= wcnt_q + 1'b1;
        ecnt_q <= e_sum;
      end
    end
  end

  p_err_cap_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ecnt_q <= EW'(ERR_LIM));
  p_win_cap_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wcnt_q <= WW'(WIN_LEN - 1));
endmodule

// File: rtl/prbs_det_irq.sv
module prbs_det_irq (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic err_evt_i,
  input  logic sync_evt_i,
  input  logic err_clr_i,
  input  logic sync_clr_i,
  input  logic err_ie_i,
  input  logic sync_ie_i,
  output logic err_flag_o,
  output logic sync_flag_o,
  output logic irq_o
);
  logic [1:0] set, clr, flag_q;

  assign set = {sync_evt_i, err_evt_i};
  assign clr = {sync_clr_i, err_clr_i};

  for (genvar i = 0; i < 2; i++) begin : g_flag
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)     flag_q[i] <= 1'b0;
      else if (set[i]) flag_q[i] <= 1'b1;
      else if (clr[i]) flag_q[i] <= 1'b0;
    end
  end

  assign err_flag_o  = flag_q[0];
  assign sync_flag_o = flag_q[1];
  assign irq_o       = (flag_q[0] & err_ie_i) | (flag_q[1] & sync_ie_i);

  p_err_set_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_evt_i |=> err_flag_o);
  p_sync_set_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sync_evt_i |=> sync_flag_o);
  p_clr_only_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (err_clr_i && !err_evt_i) |=> !err_flag_o);
endmodule

// File: rtl/prbs_det.sv
module prbs_det
  import prbs_det_pkg::*;
#(
  parameter int unsigned WIN_LEN = 48,
  parameter int unsigned ERR_LIM = 10
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       test_en_i,
  input  logic [1:0] pat_sel_i,
  input  logic       rx_inv_i,
  input  logic       bit_valid_i,
  input  logic       bit_i,
  input  logic       err_clr_i,
  input  logic       sync_clr_i,
  input  logic       err_ie_i,
  input  logic       sync_ie_i,
  output logic       sync_o,
  output logic       bit_err_o,
  output logic       err_flag_o,
  output logic       sync_flag_o,
  output logic       irq_o
);
  logic             en_q, run, take, d, pred, zero, mis, lose;
  logic             sync_q, sync_d, berr_q, err_evt, good;
  logic [LEN_W-1:0] acq_q, acq_last;

  assign run      = test_en_i & en_q;   // rising-edge cycle is a restart, not a bit
  assign take     = run & bit_valid_i;
  assign d        = bit_i ^ rx_inv_i;
  assign mis      = d ^ pred;
  assign good     = ~mis & ~zero;
  assign acq_last = pat_len(pat_sel_i) - 1'b1;
  assign err_evt  = take & sync_q & mis;

  prbs_det_lfsr u_lfsr (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clr_i   (~run),
    .shift_i (take),
    .load_i  (~sync_q),
    .bit_i   (d),
    .sel_i   (pat_sel_i),
    .pred_o  (pred),
    .zero_o  (zero)
  );

  prbs_det_win #(.WIN_LEN(WIN_LEN), .ERR_LIM(ERR_LIM)) u_win (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (~run | ~sync_q),
    .step_i (take & sync_q),
    .err_i  (mis),
    .lose_o (lose)
  );

  always_comb begin
    sync_d = sync_q;
    if (!run)        sync_d = 1'b0;
    else if (take) begin
      if (sync_q)    sync_d = ~lose;
      else           sync_d = good && (acq_q == acq_last);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q   <= 1'b0;
      sync_q <= 1'b0;
      berr_q <= 1'b0;
      acq_q  <= '0;
    end else begin
      en_q   <= test_en_i;
      sync_q <= sync_d;
      berr_q <= err_evt;
      if (!run || sync_q)           acq_q <= '0;
      else if (take) begin
        if (!good || acq_q == acq_last) acq_q <= '0;
        else                            acq_q <= acq_q + 1'b1;
      end
    end
  end

  prbs_det_irq u_irq (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .err_evt_i   (err_evt),
    .sync_evt_i  (sync_d ^ sync_q),
    .err_clr_i   (err_clr_i),
    .sync_clr_i  (sync_clr_i),
    .err_ie_i    (err_ie_i),
    .sync_ie_i   (sync_ie_i),
    .err_flag_o  (err_flag_o),
    .sync_flag_o (sync_flag_o),
    .irq_o       (irq_o)
  );

  assign sync_o    = sync_q;
  assign bit_err_o = berr_q;

  p_off_no_sync_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !test_en_i |=> !sync_o);
  p_lose_drop_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (take && sync_q && lose) |=> !sync_o);
  p_err_in_sync_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sync_q |=> !bit_err_o);
  p_zero_no_lock_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (take && !sync_q && zero) |=> !sync_o);
endmodule

// File: tb/prbs_det_test.sv
`timescale 1ns/1ps
module prbs_det_test;
  logic clk = 1'b0, rst_n = 1'b0;
  logic test_en = 0, inv = 0, valid = 0, bitv = 0, eclr = 0, sclr = 0, eie = 0, sie = 0;
  logic [1:0] sel = 2'b00;
  logic sync, berr, eflag, sflag, irq;
  int checks = 0, errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  prbs_det uut (
    .clk_i(clk), .rst_ni(rst_n), .test_en_i(test_en), .pat_sel_i(sel),
    .rx_inv_i(inv), .bit_valid_i(valid), .bit_i(bitv), .err_clr_i(eclr),
    .sync_clr_i(sclr), .err_ie_i(eie), .sync_ie_i(sie), .sync_o(sync),
    .bit_err_o(berr), .err_flag_o(eflag), .sync_flag_o(sflag), .irq_o(irq)
  );

  // reference model
  logic [19:0] ms = '0;
  int mc = 0, mw = 0, me = 0;
  bit msync = 0, men_q = 0, mbe = 0, mef = 0, msf = 0;
  // pattern generator
  logic [19:0] gst = 20'h1;
  int since_sync = 0;

  function automatic int plen(input logic [1:0] s);
    case (s) 2'd0: return 15; 2'd1: return 20; 2'd2: return 11; default: return 7; endcase
  endfunction
  function automatic int ptap(input logic [1:0] s);
    case (s) 2'd0: return 14; 2'd1: return 17; 2'd2: return 9; default: return 6; endcase
  endfunction
  function automatic logic [19:0] lmask(input logic [1:0] s);
    return 20'((64'd1 << plen(s)) - 1);
  endfunction
  function automatic bit mpred(input logic [19:0] s, input logic [1:0] p);
    return s[plen(p)-1] ^ s[ptap(p)-1];
  endfunction

  task automatic model_edge();
    bit nsync, d, p, mis;
    int e;
    nsync = msync; mbe = 0;
    if (!test_en || !men_q) begin
      nsync = 0; ms = '0; mc = 0; mw = 0; me = 0;
    end else if (valid) begin
      d = bitv ^ inv; p = mpred(ms, sel); mis = (d != p);
      if (!msync) begin
        if (mis || ((ms & lmask(sel)) == 0)) mc = 0;
        else if (mc == plen(sel) - 1) begin nsync = 1; mc = 0; mw = 0; me = 0; end
        else mc++;
        ms = {ms[18:0], d} & lmask(sel);
      end else begin
        mbe = mis; e = me + int'(mis);
        if (e > 10) begin nsync = 0; mc = 0; mw = 0; me = 0; end
        else if (mw == 47) begin mw = 0; me = 0; end
        else begin mw++; me = e; end
        ms = {ms[18:0], p} & lmask(sel);
      end
    end
    if (mbe) mef = 1; else if (eclr) mef = 0;
    if (nsync != msync) msf = 1; else if (sclr) msf = 0;
    msync = nsync;
    men_q = test_en;
  endtask

  task automatic chk(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%0b exp=%0b at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic step();
    @(posedge clk);
    model_edge();
    @(negedge clk);
    chk("R2 sync", sync, msync);
    chk("R5 bit_err", berr, mbe);
    chk("R9 err_flag", eflag, mef);
    chk("R10 sync_flag", sflag, msf);
    chk("R11 irq", irq, (mef & eie) | (msf & sie));
    if (sync) since_sync++; else since_sync = 0;
  endtask

  task automatic send(input logic b);
    valid = 1; bitv = b; step(); valid = 0;
  endtask

  function automatic logic gen_bit();
    logic b;
    b = mpred(gst, sel);
    gst = {gst[18:0], b} & lmask(sel);
    return b;
  endfunction

  task automatic send_prbs(input logic flip);
    logic b;
    b = gen_bit();
    send(b ^ inv ^ flip);
  endtask

  task automatic restart();
    test_en = 0; step(); test_en = 1; step();
  endtask

  task automatic acquire();
    for (int i = 0; i < 200 && !sync; i++) send_prbs(0);
    since_sync = 0;
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog act=hung exp=done");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    #1;
    chk("R1 sync reset", sync, 0);
    chk("R1 bit_err reset", berr, 0);
    chk("R1 flags reset", eflag | sflag, 0);
    chk("R1 irq reset", irq, 0);
    repeat (2) @(negedge clk);
    rst_n = 1;
    eie = 1; sie = 1;

    // R2: every pattern, lock after exactly L clean bits
    for (int s = 0; s < 4; s++) begin
      sel = 2'(s); gst = 20'h5A3 & lmask(sel);
      restart();
      for (int i = 0; i < plen(sel) * 2; i++) send_prbs(0);
      chk("R2 lock per pattern", sync, 1);
      sclr = 1; step(); sclr = 0;
    end

    // R3: all-zero stream
    sel = 2'b10; restart();
    for (int i = 0; i < 60; i++) send(0);
    chk("R3 zero stream no lock", sync, 0);

    // R4: inversion
    inv = 1; restart(); gst = 20'h2B;
    for (int i = 0; i < 40; i++) send_prbs(0);
    chk("R4 inverted locks with rx_inv", sync, 1);
    inv = 0; restart();
    for (int i = 0; i < 60; i++) send(~gen_bit());
    chk("R4 inverted no lock without rx_inv", sync, 0);

    // R6: 10 errors keep sync, 11 drop it
    restart(); acquire();
    for (int i = 0; i < 48; i++) send_prbs(i < 10);
    chk("R6 ten errors keep sync", sync, 1);
    for (int i = 0; i < 11; i++) send_prbs(1);
    chk("R6 eleventh error drops sync", sync, 0);
    chk("R5 last error pulsed", berr, 1);

    // R7: errors straddling window boundary
    restart(); acquire();
    for (int i = 0; i < 42; i++) send_prbs(0);
    for (int i = 0; i < 12; i++) send_prbs(1);
    chk("R7 split errors keep sync", sync, 1);

    // R8: disable drops sync, bits ignored
    test_en = 0; step();
    chk("R8 disable drops sync", sync, 0);
    for (int i = 0; i < 30; i++) send_prbs(0);
    chk("R8 bits ignored while off", sync | berr, 0);

    // R9/R10: event beats clear, clear alone works
    test_en = 1; step(); acquire();
    eclr = 1; send_prbs(1); eclr = 0;
    chk("R9 event wins over clear", eflag, 1);
    eclr = 1; step(); eclr = 0;
    chk("R9 clear alone", eflag, 0);
    sclr = 1; step(); sclr = 0;
    chk("R10 clear alone", sflag, 0);
    test_en = 0; sclr = 1; step(); sclr = 0; test_en = 1;
    chk("R10 fall event wins over clear", sflag, 1);
    eie = 0; sie = 0; step();
    chk("R11 masked", irq, 0);

    // random phase
    void'($urandom(32'd4711));
    for (int n = 0; n < 40; n++) begin
      sel = 2'($urandom_range(0, 3)); inv = 1'($urandom_range(0, 1));
      gst = 20'($urandom_range(1, 1000)) & lmask(sel);
      if (gst == 0) gst = 1;
      restart();
      for (int i = 0; i < 1500; i++) begin
        eclr = ($urandom_range(0, 19) == 0);
        sclr = ($urandom_range(0, 19) == 0);
        if ($urandom_range(0, 99) == 0) begin eie = ~eie; sie = 1'($urandom_range(0, 1)); end
        if ($urandom_range(0, 999) == 0) begin test_en = 0; step(); test_en = 1; end
        else if ($urandom_range(0, 4) == 0) step();
        else send_prbs($urandom_range(0, 199) < 5);
      end
      eclr = 0; sclr = 0;
    end

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule